// File: doc/BRIEF.md
# Ultra DMA Device-Side Burst Controller

This block sits at the device end of a parallel ATA-style bus and runs Ultra DMA data bursts. It decides when the shared control pins switch to their burst meanings. For that, three things must be true at once: an Ultra DMA transfer mode is enabled, exactly one DMA command (read or write) is pending, and the request/acknowledge handshake with the host has completed. It stays in burst until the host withdraws its acknowledge.

In a data-in (read) burst the device owns the 16-bit bus and a strobe of its own. It pulls words from an internal read queue and marks each word with one strobe transition, rising or falling. The host input means "host ready" in this burst, and the device pauses when it is negated. In a data-out (write) burst the host owns the bus and the strobe. Every transition of the host strobe pushes the word on the bus into an internal write queue. The device output means "device ready" and follows the write queue's space. A host stop request ends a burst cleanly: the device finishes the word in flight, withdraws its request, and waits for the acknowledge to drop.

All host-driven control inputs pass through a two-flop synchronizer. The bus input is delayed through a matching two-stage pipe, so a captured word lines up with the strobe transition that marks it.

Top module: `udb_device_burst`

## Requirements
- R1: `dev_req_o` rises one clock after `mode_ultra_i` is high with exactly one of `cmd_rd_i`/`cmd_wr_i` high. `burst_o` rises only from that requesting state, after the synchronized acknowledge is seen high.
- R2: Once the synchronized `host_ack_i` is low, the next clock leaves the burst. After that, `burst_o`, `bus_oe_o` and `dev_line_o` are all 0.
- R3: In a read burst, every popped read-queue word appears on `bus_o` one clock before `dev_line_o` toggles once for it. The strobe starts at 0 in each burst, and every toggle, rising or falling, marks exactly one word.
- R4: In a read burst, no word is popped while the synchronized host-ready input is low. Within 4 clocks of that pin going low, `dev_line_o` stops changing. Popping resumes after the pin returns high.
- R5: In a write burst, every transition of `host_line_i`, rising or falling, gives one `wrq_push_o` pulse. The pulse appears 3 clocks after the pin changes, with `wrq_data_o` equal to the `bus_i` value driven together with that transition.
- R6: In a write burst, while no stop has been taken, `dev_line_o` equals the inverse of `wrq_full_i`. During a stop it is 0.
- R7: A synchronized `host_stop_i` in a burst drops `dev_req_o` on the next clock and blocks new pops. It still lets a pending strobe toggle complete, and it keeps `burst_o` high until the acknowledge drops.
- R8: `bus_oe_o` is 1 only in a read burst. The bus is released in idle, while requesting, and in every write burst.
- R9: A change on any host control pin has no effect on the block's state before the second clock edge after it.
- R10: With `mode_ultra_i` low, or with both commands high, no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ultra_i | input | 1 | Ultra DMA transfer mode selected |
| cmd_rd_i | input | 1 | Pending read DMA command needs data |
| cmd_wr_i | input | 1 | Pending write DMA command needs data |
| host_ack_i | input | 1 | Host acknowledge, active high |
| host_line_i | input | 1 | Host ready (read burst) or host strobe (write burst) |
| host_stop_i | input | 1 | Host stop request |
| dev_req_o | output | 1 | Device DMA request, active high |
| dev_line_o | output | 1 | Device strobe (read burst) or device ready (write burst), else 0 |
| burst_o | output | 1 | Pins carry their burst meanings |
| bus_i | input | 16 | Data bus as seen from the pins |
| bus_o | output | 16 | Data driven in a read burst |
| bus_oe_o | output | 1 | Bus output enable |
| rdq_valid_i | input | 1 | Read queue has a word |
| rdq_data_i | input | 16 | Read queue head word |
| rdq_pop_o | output | 1 | Take the read queue head this clock |
| wrq_full_i | input | 1 | Write queue has no space |
| wrq_push_o | output | 1 | Write queue push strobe |
| wrq_data_o | output | 16 | Word pushed into the write queue |

## Verification
Two pairs of events are driven into the same clock on purpose. In a read burst, the stop request and the return of host ready reach the synchronizer outputs together. A pop would be allowed that cycle, so stop must win: no word leaves the queue, and any toggle already pending still completes. In a write burst, the last strobe transition and the release of the acknowledge are synchronized on the same edge. The word must still be pushed, and the burst must close on that same clock. A cycle-accurate behavioural model in the bench judges both cases, and the bench also checks the totals of pushes and pops.

// File: rtl/udb_pkg.sv
package udb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_DRAIN = 2'd3
  } udb_state_e;

  // A request is allowed only with the mode on and exactly one command pending.
  function automatic logic want_burst(input logic ultra, input logic rd, input logic wr);
    return ultra & (rd ^ wr);
  endfunction

  // A strobe transition in either direction.
  function automatic logic any_edge(input logic now_v, input logic was_v);
    return now_v ^ was_v;
  endfunction
endpackage

// File: rtl/udb_sync.sv
module udb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/udb_ctrl.sv
module udb_ctrl
  import udb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_i,
  input  logic       cmd_rd_i,
  input  logic       ack_s_i,
  input  logic       stop_s_i,
  output udb_state_e st_o,
  output logic       dir_rd_o
);
  udb_state_e st_q, st_d;
  logic       dir_q, dir_d;

  always_comb begin
    st_d  = st_q;
    dir_d = dir_q;
    unique case (st_q)
      ST_IDLE: if (want_i) begin
        st_d  = ST_REQ;
        dir_d = cmd_rd_i;
      end
      ST_REQ: begin
        if (!want_i)      st_d = ST_IDLE;
        else if (ack_s_i) st_d = ST_BURST;
      end
      ST_BURST: begin
        if (!ack_s_i)      st_d = ST_IDLE;
        else if (stop_s_i) st_d = ST_DRAIN;
      end
      ST_DRAIN: if (!ack_s_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
    end
  end

  assign st_o     = st_q;
  assign dir_rd_o = dir_q;

  // R2: a lost acknowledge closes any burst on the next clock
  a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BURST || st_q == ST_DRAIN) && !ack_s_i) |=> (st_q == ST_IDLE));
  // R1: the burst is entered only from the request state with acknowledge seen
  a_r1_entry_path: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST && $past(st_q) != ST_BURST) |-> ($past(st_q) == ST_REQ && $past(ack_s_i)));
  // R7: a stop in a live burst moves to the draining state
  a_r7_stop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST && ack_s_i && stop_s_i) |=> (st_q == ST_DRAIN));
endmodule

// File: rtl/udb_rd_eng.sv
module udb_rd_eng #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          fin_i,
  input  logic          clr_i,
  input  logic          ready_i,
  input  logic          stop_i,
  input  logic          qv_i,
  input  logic [DW-1:0] qd_i,
  output logic          pop_o,
  output logic          strobe_o,
  output logic [DW-1:0] data_o
);
  logic          phase_q;
  logic          strobe_q;
  logic [DW-1:0] data_q;
  logic          fire_w;

  assign pop_o  = run_i & ready_i & qv_i & ~phase_q & ~stop_i;
  assign fire_w = phase_q & (run_i | fin_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else if (clr_i) begin
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else if (pop_o) begin
      phase_q <= 1'b1;
      data_q  <= qd_i;
    end else if (fire_w) begin
      phase_q  <= 1'b0;
      strobe_q <= ~strobe_q;
    end
  end

  assign strobe_o = strobe_q;
  assign data_o   = data_q;

  // R4: a popped word is loaded and waits for its strobe
  a_r4_pop_loads: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (phase_q && data_q == $past(qd_i)));
  // R3: the strobe moves only to mark a loaded word, or to return to 0
  a_r3_strobe_paced: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe_q) |-> ($past(phase_q) || $past(clr_i)));
endmodule

// File: rtl/udb_wr_eng.sv
module udb_wr_eng #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          line_s_i,
  input  logic [DW-1:0] bus_s_i,
  output logic          push_o,
  output logic [DW-1:0] data_o
);
  import udb_pkg::*;

  logic          line_q;
  logic          push_q;
  logic [DW-1:0] data_q;
  logic          edge_w;
  logic          cap_w;

  assign edge_w = any_edge(line_s_i, line_q);
  assign cap_w  = act_i & edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      push_q <= 1'b0;
      data_q <= '0;
    end else begin
      line_q <= line_s_i;
      push_q <= cap_w;
      if (cap_w) data_q <= bus_s_i;
    end
  end

  assign push_o = push_q;
  assign data_o = data_q;

  // R5: a push carries the bus value seen with the strobe transition
  a_r5_push_word: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> (data_q == $past(bus_s_i)));
endmodule

// File: rtl/udb_device_burst.sv
module udb_device_burst
  import udb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ultra_i,
  input  logic          cmd_rd_i,
  input  logic          cmd_wr_i,
  input  logic          host_ack_i,
  input  logic          host_line_i,
  input  logic          host_stop_i,
  output logic          dev_req_o,
  output logic          dev_line_o,
  output logic          burst_o,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  input  logic          rdq_valid_i,
  input  logic [DW-1:0] rdq_data_i,
  output logic          rdq_pop_o,
  input  logic          wrq_full_i,
  output logic          wrq_push_o,
  output logic [DW-1:0] wrq_data_o
);
  localparam int CW = 3;

  logic [CW-1:0] ctl_s;
  logic [DW-1:0] bus_s;
  logic          ack_s, line_s, stop_s;
  udb_state_e    st;
  logic          dir_rd;
  logic          burst_w, rd_run_w, rd_fin_w, wr_act_w;
  logic          strobe_w;

  udb_sync #(.W(CW), .STAGES(2)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({host_stop_i, host_line_i, host_ack_i}), .q_o(ctl_s));

  udb_sync #(.W(DW), .STAGES(2)) u_bus_dly (
    .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s));

  assign ack_s  = ctl_s[0];
  assign line_s = ctl_s[1];
  assign stop_s = ctl_s[2];

  udb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .want_i(want_burst(mode_ultra_i, cmd_rd_i, cmd_wr_i)),
    .cmd_rd_i(cmd_rd_i), .ack_s_i(ack_s), .stop_s_i(stop_s),
    .st_o(st), .dir_rd_o(dir_rd));

  assign burst_w  = (st == ST_BURST) || (st == ST_DRAIN);
  assign rd_run_w = (st == ST_BURST) && dir_rd;
  assign rd_fin_w = (st == ST_DRAIN) && dir_rd;
  assign wr_act_w = burst_w && !dir_rd;

  udb_rd_eng #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .run_i(rd_run_w), .fin_i(rd_fin_w), .clr_i(!burst_w),
    .ready_i(line_s), .stop_i(stop_s),
    .qv_i(rdq_valid_i), .qd_i(rdq_data_i),
    .pop_o(rdq_pop_o), .strobe_o(strobe_w), .data_o(bus_o));

  udb_wr_eng #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .act_i(wr_act_w), .line_s_i(line_s), .bus_s_i(bus_s),
    .push_o(wrq_push_o), .data_o(wrq_data_o));

  assign dev_req_o  = (st == ST_REQ) || (st == ST_BURST);
  assign burst_o    = burst_w;
  assign bus_oe_o   = burst_w && dir_rd;
  assign dev_line_o = (burst_w && dir_rd)          ? strobe_w :
                      ((st == ST_BURST) && !dir_rd) ? !wrq_full_i : 1'b0;

  // R8: the device never drives the bus while a write capture is landing
  a_r8_no_drive_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !wrq_push_o);
endmodule

// File: tb/sim_udb_device_burst.sv
`timescale 1ns/1ps
module sim_udb_device_burst;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_ultra = 0, t_crd = 0, t_cwr = 0, t_ack = 0, t_line = 0, t_stop = 0;
  logic [15:0] t_bus = '0;
  logic t_rv = 0, t_wfull = 0;
  logic [15:0] rd_word = 16'h1000;
  logic dev_req, dev_line, burst, bus_oe, rd_pop, wr_push;
  logic [15:0] bus_o, wr_data;

  int n_vec = 0, n_fail = 0, n_push = 0, n_toggle = 0;
  bit done = 0;

  // reference model state
  int m_st; bit m_dir, m_ph, m_stb, m_lq, m_push, m_popped;
  logic [15:0] m_dq, m_wd;
  bit qa[$], ql[$], qs[$];
  logic [15:0] qb[$];
  logic [15:0] exp_wq[$];

  always #2 clk = ~clk;

  udb_device_burst u0 (
    .clk(clk), .rst_n(rst_n), .mode_ultra_i(t_ultra), .cmd_rd_i(t_crd), .cmd_wr_i(t_cwr),
    .host_ack_i(t_ack), .host_line_i(t_line), .host_stop_i(t_stop),
    .dev_req_o(dev_req), .dev_line_o(dev_line), .burst_o(burst),
    .bus_i(t_bus), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .rdq_valid_i(t_rv), .rdq_data_i(rd_word), .rdq_pop_o(rd_pop),
    .wrq_full_i(t_wfull), .wrq_push_o(wr_push), .wrq_data_o(wr_data));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_dir = 0; m_ph = 0; m_stb = 0; m_lq = 0; m_push = 0; m_popped = 0;
    m_dq = '0; m_wd = '0;
    qa = '{0, 0}; ql = '{0, 0}; qs = '{0, 0}; qb = '{16'h0, 16'h0};
  endtask

  task automatic model_step();
    bit o_ack = qa[0];
    bit o_line = ql[0];
    bit o_stop = qs[0];
    logic [15:0] o_bus = qb[0];
    bit want = t_ultra && (t_crd != t_cwr);
    bit inb = (m_st >= 2);
    bit pop = (m_st == 2) && m_dir && o_line && t_rv && !m_ph && !o_stop;
    int nst = m_st;
    bit ndir = m_dir;
    case (m_st)
      0: if (want) begin nst = 1; ndir = t_crd; end
      1: if (!want) nst = 0; else if (o_ack) nst = 2;
      2: if (!o_ack) nst = 0; else if (o_stop) nst = 3;
      default: if (!o_ack) nst = 0;
    endcase
    m_popped = pop;
    if (!inb) begin m_ph = 0; m_stb = 0; end
    else if (pop) begin m_ph = 1; m_dq = rd_word; end
    else if (m_ph && m_dir) begin m_ph = 0; m_stb = !m_stb; end
    m_push = inb && !m_dir && (o_line != m_lq);
    if (m_push) m_wd = o_bus;
    m_lq = o_line;
    m_st = nst; m_dir = ndir;
    qa.push_back(t_ack);   void'(qa.pop_front());
    ql.push_back(t_line);  void'(ql.pop_front());
    qs.push_back(t_stop);  void'(qs.pop_front());
    qb.push_back(t_bus);   void'(qb.pop_front());
  endtask

  task automatic tick();
    bit e_oe, e_line, e_pop;
    @(negedge clk);
    model_step();
    e_oe = (m_st >= 2) && m_dir;
    e_line = e_oe ? m_stb : ((m_st == 2 && !m_dir) ? !t_wfull : 1'b0);
    e_pop = (m_st == 2) && m_dir && ql[0] && t_rv && !m_ph && !qs[0];
    chk("R1 dev_req", dev_req, (m_st == 1 || m_st == 2));
    chk("R2 burst", burst, (m_st >= 2));
    chk("R8 bus_oe", bus_oe, e_oe);
    chk(m_dir ? "R3 strobe" : "R6 ready", dev_line, e_line);
    chk("R4 pop", rd_pop, e_pop);
    chk("R5 push", wr_push, m_push);
    if (e_oe) chk("R3 bus data", bus_o, m_dq);
    if (wr_push) begin
      n_push++;
      if (exp_wq.size() > 0) chk("R5 push word", wr_data, exp_wq.pop_front());
      else chk("R5 unexpected push", 1, 0);
      chk("R5 model word", wr_data, m_wd);
    end
    if (m_popped) rd_word = rd_word + 16'h0011;
  endtask

  task automatic wait_burst(input bit lvl);
    for (int i = 0; i < 20 && burst != lvl; i++) tick();
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic hold;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset dev_req", dev_req, 0);
    chk("R8 reset bus_oe", bus_oe, 0);
    chk("R2 reset line", dev_line, 0);
    rst_n = 1'b1;

    // R10: no request with mode off or both commands
    t_ultra = 1; t_crd = 1; t_cwr = 1;
    repeat (5) tick();
    chk("R10 both cmds", dev_req, 0);
    t_ultra = 0; t_cwr = 0;
    repeat (5) tick();
    chk("R10 mode off", dev_req, 0);

    // read burst
    t_ultra = 1; t_line = 1; t_rv = 1;
    tick();
    chk("R1 request raised", dev_req, 1);
    t_ack = 1;
    tick(); chk("R9 ack not early", burst, 0);
    tick(); chk("R9 ack still synced", burst, 0);
    tick(); chk("R1 burst entered", burst, 1);
    for (int i = 0; i < 24; i++) begin
      t_rv = (i % 7) != 3;
      tick();
    end
    t_rv = 1;
    // R4: host-ready negated
    t_line = 0;
    repeat (4) tick();
    hold = dev_line;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R4 strobe frozen", dev_line, hold);
      chk("R4 no pop while unready", rd_pop, 0);
    end
    t_line = 1;
    repeat (12) tick();
    // concurrent: stop and ready drop/rise together
    t_line = 0; repeat (4) tick();
    t_line = 1; t_stop = 1;
    repeat (4) tick();
    chk("R7 request dropped", dev_req, 0);
    chk("R7 burst held", burst, 1);
    hold = dev_line;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R7 no pop after stop", rd_pop, 0);
      chk("R7 strobe settled", dev_line, hold);
    end
    t_ack = 0;
    repeat (3) tick();
    chk("R2 released burst", burst, 0);
    chk("R2 released bus", bus_oe, 0);
    chk("R2 released line", dev_line, 0);
    t_stop = 0; t_crd = 0; t_line = 0;
    repeat (4) tick();

    // write burst
    t_cwr = 1;
    tick();
    t_ack = 1;
    wait_burst(1);
    chk("R8 write burst bus off", bus_oe, 0);
    for (int i = 0; i < 20; i++) begin
      t_bus = 16'hA000 + 16'(i * 37);
      t_line = !t_line;
      t_wfull = (i % 5) == 2;
      exp_wq.push_back(t_bus);
      n_toggle++;
      tick();
      if (i % 3 == 1) tick();
    end
    t_wfull = 0;
    repeat (4) tick();
    chk("R6 ready with space", dev_line, 1);
    // concurrent: last strobe edge with acknowledge release
    t_bus = 16'h5A5A; t_line = !t_line; t_ack = 0;
    exp_wq.push_back(t_bus); n_toggle++;
    repeat (5) tick();
    chk("R2 write burst closed", burst, 0);
    chk("R5 push count", n_push, n_toggle);
    chk("R5 queue drained", exp_wq.size(), 0);
    t_cwr = 0;
    repeat (3) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule